// File: doc/BRIEF.md
# RTC Alarm and Periodic Event Interrupt Unit

This block sits beside a real-time calendar counter and turns its output into a single interrupt line. It holds an alarm date and time as six packed-BCD bytes. On each one-second tick it compares those bytes with the calendar's current value. When every field is equal, it sets a sticky alarm flag. Independently, it can raise a single-cycle timer interrupt when a selected calendar event occurs: a new second, minute, hour or day.

Software reaches the block through a byte-wide register port. Writes take effect at the clock edge. Read data is registered, so it appears one cycle after the address. The status flags are cleared by writing one to them. The usual way to change the alarm is to disable the alarm interrupt, rewrite the six alarm bytes, and then enable it again.

Top module: `rtc_alm_irq`

## Requirements
- R1: After reset the interrupt register (offset 0x0F) reads 0x00, every alarm byte reads 0x00, the alarm flag is clear, the power-up flag (status offset 0x0E bit 7) is set, and `irq_o` is low.
- R2: Alarm bytes are written and read back at offsets 0x07 to 0x0C, holding seconds, minutes, hours, day, month and year in that order. Read data appears on `rd_data_o` one clock after the address is presented.
- R3: On a cycle where `cal_evt_i[0]` (the second tick) is high and all six current-time bytes equal the alarm bytes, the alarm flag (status bit 6) is set at that clock edge.
- R4: The alarm flag is not set if any single field differs, or if the fields match but no second tick occurs.
- R5: Writing 1 to status bit 6 or bit 7 clears that flag. Writing 0 to a status bit leaves it unchanged.
- R6: While the alarm flag is set and the alarm enable (interrupt register bit 3) is 1, `irq_o` stays high. It drops on the edge where the flag is cleared or the enable is written to 0.
- R7: With the timer enable (interrupt register bit 2) set, `irq_o` pulses high for one cycle, one clock after the selected event input is high. Bits 1:0 select the event: 0 = second (`cal_evt_i[0]`), 1 = minute (`cal_evt_i[1]`), 2 = hour (`cal_evt_i[2]`), 3 = day (`cal_evt_i[3]`).
- R8: An event that is not selected, or any event while the timer enable is 0, produces no pulse on `irq_o`.
- R9: Interrupt register bits 7:4 ignore writes and read as 0.
- R10: If an alarm match on a tick coincides with a write-one-to-clear of the alarm flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_time_i | input | 48 | Current BCD time; byte i is field i (0 = seconds … 5 = year) |
| cal_evt_i | input | 4 | One-cycle event pulses: second, minute, hour, day |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register offset |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The hardest situation to reach is an alarm match landing on the same edge as a write-one-to-clear of the flag. The stimulus sets up a matching time, then drives the tick and the clear write together on one cycle. A table also moves the current time away from the alarm in one field at a time, so that a stuck comparator on any single field shows up. The timer pulses are checked on both the cycle they appear and the cycle after, to confirm they last only one cycle.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int BYTE_W = 8;
  localparam int NFIELD = 6;
  localparam int ADDR_W = 5;
  localparam int NEVT   = 4;
  localparam logic [ADDR_W-1:0] ALM_BASE  = 5'h07;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h0E;
  localparam logic [ADDR_W-1:0] IEN_ADDR  = 5'h0F;
  localparam int STAT_ALM_BIT = 6;
  localparam int STAT_PWR_BIT = 7;
  localparam int IEN_TMR_BIT  = 2;
  localparam int IEN_ALM_BIT  = 3;
  localparam int IEN_W        = 4;
endpackage

// File: rtl/rtc_alm_store.sv
module rtc_alm_store #(
  parameter int BW = 8,
  parameter int NF = 6,
  parameter int AW = 5,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [BW-1:0]  wdata,
  output logic [NF*BW-1:0] alm_flat
);
  for (genvar i = 0; i < NF; i++) begin : g_byte
    logic [BW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr && addr == BASE + AW'(i)) q <= wdata;
    end
    assign alm_flat[i*BW +: BW] = q;
  end
endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp #(
  parameter int BW = 8,
  parameter int NF = 6
) (
  input  logic [NF*BW-1:0] cur,
  input  logic [NF*BW-1:0] alm,
  output logic             match
);
  logic [NF-1:0] eq;
  for (genvar i = 0; i < NF; i++) begin : g_eq
    assign eq[i] = (cur[i*BW +: BW] == alm[i*BW +: BW]);
  end
  assign match = &eq;
endmodule

// File: rtl/rtc_alm_evsel.sv
module rtc_alm_evsel #(
  parameter int NE = 4,
  localparam int SW = $clog2(NE)
) (
  input  logic [NE-1:0] evt,
  input  logic [SW-1:0] sel,
  output logic          fire
);
  assign fire = evt[sel];
endmodule

// File: rtl/rtc_alm_irq.sv
module rtc_alm_irq
  import rtc_alm_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NF = NFIELD,
  parameter int AW = ADDR_W,
  parameter int NE = NEVT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NF*BW-1:0] cal_time_i,
  input  logic [NE-1:0]    cal_evt_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [BW-1:0]    rd_data_o,
  output logic             irq_o
);
  localparam int SW = $clog2(NE);

  logic [NF*BW-1:0] alm_flat;
  logic             match, fire;
  logic [IEN_W-1:0] ien_q, ien_d;
  logic             alm_flag, alm_flag_d, pwr_flag, pwr_flag_d;
  logic             irq_q;
  logic [BW-1:0]    rd_q, rd_d;
  logic             stat_wr, ien_wr;

  rtc_alm_store #(.BW(BW), .NF(NF), .AW(AW), .BASE(ALM_BASE)) u_store (
    .clk(clk), .rst(rst), .wr(wr_i), .addr(addr_i), .wdata(wdata_i),
    .alm_flat(alm_flat)
  );

  rtc_alm_cmp #(.BW(BW), .NF(NF)) u_cmp (
    .cur(cal_time_i), .alm(alm_flat), .match(match)
  );

  rtc_alm_evsel #(.NE(NE)) u_evsel (
    .evt(cal_evt_i), .sel(ien_q[SW-1:0]), .fire(fire)
  );

  assign stat_wr = wr_i && (addr_i == STAT_ADDR);
  assign ien_wr  = wr_i && (addr_i == IEN_ADDR);

  always_comb begin
    ien_d = ien_wr ? wdata_i[IEN_W-1:0] : ien_q;
    // a match on the tick wins over a clear in the same cycle
    if (cal_evt_i[0] && match)                alm_flag_d = 1'b1;
    else if (stat_wr && wdata_i[STAT_ALM_BIT]) alm_flag_d = 1'b0;
    else                                       alm_flag_d = alm_flag;
    pwr_flag_d = (stat_wr && wdata_i[STAT_PWR_BIT]) ? 1'b0 : pwr_flag;
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NF; i++)
      if (addr_i == ALM_BASE + AW'(i)) rd_d = alm_flat[i*BW +: BW];
    if (addr_i == STAT_ADDR) begin
      rd_d[STAT_ALM_BIT] = alm_flag;
      rd_d[STAT_PWR_BIT] = pwr_flag;
    end
    if (addr_i == IEN_ADDR) rd_d[IEN_W-1:0] = ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q    <= '0;
      alm_flag <= 1'b0;
      pwr_flag <= 1'b1;
      irq_q    <= 1'b0;
      rd_q     <= '0;
    end else begin
      ien_q    <= ien_d;
      alm_flag <= alm_flag_d;
      pwr_flag <= pwr_flag_d;
      irq_q    <= (alm_flag_d && ien_d[IEN_ALM_BIT]) || (fire && ien_q[IEN_TMR_BIT]);
      rd_q     <= rd_d;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

  assert_alarm_set_R3: assert property (@(posedge clk) disable iff (rst)
    (cal_evt_i[0] && match) |=> alm_flag);
  assert_no_tick_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!cal_evt_i[0] && !alm_flag) |=> !alm_flag);
  assert_zero_write_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !wdata_i[STAT_ALM_BIT] && alm_flag) |=> alm_flag);
  assert_pwr_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata_i[STAT_PWR_BIT]) |=> !pwr_flag);
  assert_irq_held_R6: assert property (@(posedge clk) disable iff (rst)
    (alm_flag && ien_q[IEN_ALM_BIT]) |-> irq_o);
  assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !alm_flag && ien_q[IEN_ALM_BIT:IEN_TMR_BIT] == 2'b00 && !(cal_evt_i[0] && match))
      |=> !irq_o);
endmodule

// File: tb/rtc_alm_irq_tb.sv
module rtc_alm_irq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] cal_time = '0;
  logic [3:0]  cal_evt = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rtc_alm_irq u_dut (
    .clk(clk), .rst(rst), .cal_time_i(cal_time), .cal_evt_i(cal_evt),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
  );

  localparam logic [47:0] ALM = 48'h24_12_31_23_59_58;
  // {expected flag, current time}
  localparam logic [48:0] VEC [8] = '{
    {1'b1, 48'h24_12_31_23_59_58},
    {1'b0, 48'h24_12_31_23_59_57},
    {1'b0, 48'h24_12_31_23_58_58},
    {1'b0, 48'h24_12_31_22_59_58},
    {1'b0, 48'h24_12_30_23_59_58},
    {1'b0, 48'h24_11_31_23_59_58},
    {1'b0, 48'h25_12_31_23_59_58},
    {1'b1, 48'h24_12_31_23_59_58}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); wr = 1'b0; addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); cal_evt = 4'b0001;
    @(negedge clk); cal_evt = 4'b0000;
  endtask

  task automatic pulse_evt(input logic [3:0] e, input logic exp, input string tag);
    @(negedge clk); cal_evt = e;
    @(negedge clk); cal_evt = 4'b0000;
    chk(tag, {7'b0, irq}, {7'b0, exp});
    @(negedge clk);
    chk(tag, {7'b0, irq}, 8'h00);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd_reg(5'h0F, d); chk("R1 ien", d, 8'h00);
    rd_reg(5'h0E, d); chk("R1 status", d, 8'h80);
    rd_reg(5'h0A, d); chk("R1 alarm byte", d, 8'h00);

    // R2 alarm bytes write/readback
    for (int i = 0; i < 6; i++) wr_reg(5'h07 + 5'(i), ALM[i*8 +: 8]);
    for (int i = 0; i < 6; i++) begin
      rd_reg(5'h07 + 5'(i), d); chk("R2 alarm readback", d, ALM[i*8 +: 8]);
    end

    // R3/R4 table: one field off at a time
    for (int k = 0; k < 8; k++) begin
      cal_time = VEC[k][47:0];
      tick();
      rd_reg(5'h0E, d);
      chk(VEC[k][48] ? "R3 match sets flag" : "R4 mismatch no flag", d & 8'h40, {1'b0, VEC[k][48], 6'b0});
      wr_reg(5'h0E, 8'h40);
    end

    // R4 match without tick
    cal_time = ALM;
    repeat (4) @(negedge clk);
    rd_reg(5'h0E, d); chk("R4 no tick", d & 8'h40, 8'h00);

    // R5 write zero keeps, write one clears
    tick();
    wr_reg(5'h0E, 8'h00);
    rd_reg(5'h0E, d); chk("R5 zero write keeps", d, 8'hC0);
    wr_reg(5'h0E, 8'h80);
    rd_reg(5'h0E, d); chk("R5 pwr clear", d, 8'h40);
    wr_reg(5'h0E, 8'h40);
    rd_reg(5'h0E, d); chk("R5 alarm clear", d, 8'h00);

    // R6 level alarm interrupt
    wr_reg(5'h0F, 8'h08);
    chk("R6 idle", {7'b0, irq}, 8'h00);
    tick();
    chk("R6 raised", {7'b0, irq}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R6 held", {7'b0, irq}, 8'h01);
    wr_reg(5'h0E, 8'h40);
    chk("R6 cleared by w1c", {7'b0, irq}, 8'h00);
    tick();
    chk("R6 raised again", {7'b0, irq}, 8'h01);
    wr_reg(5'h0F, 8'h00);
    chk("R6 dropped by disable", {7'b0, irq}, 8'h00);
    rd_reg(5'h0E, d); chk("R6 flag still set", d & 8'h40, 8'h40);

    // R10 set wins over same-cycle clear
    @(negedge clk); cal_evt = 4'b0001; wr = 1'b1; addr = 5'h0E; wdata = 8'h40;
    @(negedge clk); cal_evt = 4'b0000; wr = 1'b0;
    rd_reg(5'h0E, d); chk("R10 set wins", d & 8'h40, 8'h40);
    wr_reg(5'h0E, 8'h40);
    cal_time = 48'h24_12_31_23_59_00;

    // R7/R8 timer pulses
    wr_reg(5'h0F, 8'h05);
    pulse_evt(4'b0010, 1'b1, "R7 minute pulse");
    pulse_evt(4'b0001, 1'b0, "R8 unselected second");
    wr_reg(5'h0F, 8'h04);
    pulse_evt(4'b0001, 1'b1, "R7 second pulse");
    wr_reg(5'h0F, 8'h06);
    pulse_evt(4'b0100, 1'b1, "R7 hour pulse");
    wr_reg(5'h0F, 8'h07);
    pulse_evt(4'b1000, 1'b1, "R7 day pulse");
    pulse_evt(4'b0100, 1'b0, "R8 unselected hour");
    wr_reg(5'h0F, 8'h03);
    pulse_evt(4'b1000, 1'b0, "R8 timer disabled");

    // R9 upper bits ignored
    wr_reg(5'h0F, 8'hF1);
    rd_reg(5'h0F, d); chk("R9 upper bits zero", d, 8'h01);
    wr_reg(5'h0F, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule